// File: doc/BRIEF.md
# Store Buffer with Load Bypass

This block sits between one processor request port and one memory port and relaxes ordering the way a total-store-order machine does. Stores are accepted into a small queue and retired to memory one by one, oldest first, whenever the memory port is not needed by the processor. A load does not wait behind queued stores. When its address matches queued stores it is answered at once from the newest of them. Otherwise it goes to memory ahead of every queued store.

An exchange (atomic swap) request is the ordering barrier. The block first lets the queue empty into memory. It then issues one swap transaction that writes the new word and returns the previous one. After a load that misses, or an exchange, the processor is held until the memory answers, so reads stay ordered against each other and against every later access.

The processor presents a request with `cpu_valid`. The request is taken on a rising edge where `cpu_stall` is low. The memory takes a request on a rising edge where both `mem_req` and `mem_gnt` are high, and it may see a different request on the next cycle if it did not grant. Read and swap data come back with a one-cycle `mem_rvalid` pulse at least one cycle after the grant.

Top module: `stbuf_top`

## Requirements
- R1: After a synchronous reset the queue is empty, and `cpu_rvalid` and `mem_req` are low. `cpu_stall` is low while `cpu_valid` is low.
- R2: Processor operation codes are 0 load, 1 store and 2 exchange. Memory operation codes are 0 read, 1 write and 2 swap. Accepted stores reach memory as writes in the order they were accepted, with their address and data unchanged.
- R3: A store presented while the queue holds DEPTH entries sees `cpu_stall` high and is not taken.
- R4: A load whose address matches no queued store is sent to memory as a read before any queued store is written. The port always favours the processor's read or swap over draining the queue.
- R5: A load whose address matches a queued store raises `cpu_rvalid` on the cycle after it is taken, and no memory read occurs.
- R6: When several queued stores match a load address, the load returns the data of the most recently accepted one.
- R7: A load that misses holds `cpu_stall` high until the memory response arrives. It then returns `mem_rdata` on `cpu_rvalid` one cycle after `mem_rvalid`. The read request keeps the same address until it is granted.
- R8: An exchange is sent to memory as a swap only after every store accepted before it has been written. It returns the old memory word, and later loads see the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_op | input | 2 | 0 load, 1 store, 2 exchange |
| cpu_addr | input | AW | Request address |
| cpu_wdata | input | DW | Store or exchange data |
| cpu_stall | output | 1 | Request cannot be taken this cycle |
| cpu_rvalid | output | 1 | Load or exchange result valid |
| cpu_rdata | output | DW | Load or exchange result |
| mem_req | output | 1 | Memory request present |
| mem_op | output | 2 | 0 read, 1 write, 2 swap |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Write or swap data |
| mem_gnt | input | 1 | Memory takes the request this cycle |
| mem_rvalid | input | 1 | Read or swap response valid |
| mem_rdata | input | DW | Read or swap response data |

## Verification
A mixed program of stores, loads and exchanges is run twice. In the first run memory grants every cycle. In the second it grants every other cycle, which changes whether a load finds its store still queued or already retired. Both runs must give the sequential results. Directed tests then block the grant so the queue fills. With the queue full they show the stall on a further store, forwarding from the newest of three stores to one address, and a missing load overtaking all four queued writes. An exchange then drains the queue, and the test checks the write log order and the swap position in it.

// File: rtl/stbuf_pkg.sv
package stbuf_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_XCHG  = 2'd2
  } cpu_op_e;

  typedef enum logic [1:0] {
    MEM_RD   = 2'd0,
    MEM_WR   = 2'd1,
    MEM_SWAP = 2'd2
  } mem_op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LD_REQ,
    S_LD_WAIT,
    S_X_DRAIN,
    S_X_REQ,
    S_X_WAIT
  } ctrl_st_e;
endpackage

// File: rtl/stbuf_fifo.sv
module stbuf_fifo #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  input  logic [AW-1:0] lk_addr,
  output logic          lk_hit,
  output logic [DW-1:0] lk_data,
  output logic [AW-1:0] head_addr,
  output logic [DW-1:0] head_data,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [AW-1:0] a_q [DEPTH];
  logic [DW-1:0] d_q [DEPTH];
  logic [PW-1:0] head_q, tail_q;
  logic [CW-1:0] cnt_q;
  logic [DEPTH-1:0] match;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  // entry storage: written only, no reset, so it maps to plain registers or LUT memory
  always_ff @(posedge clk) begin
    if (push) begin
      a_q[tail_q] <= push_addr;
      d_q[tail_q] <= push_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) tail_q <= nxt(tail_q);
      if (pop)  head_q <= nxt(head_q);
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign match[i] = (a_q[i] == lk_addr);
  end

  // walk slots from oldest to newest; a later hit overrides, leaving the youngest
  always_comb begin
    lk_hit  = 1'b0;
    lk_data = '0;
    for (int k = 0; k < DEPTH; k++) begin
      int idx;
      idx = int'(head_q) + k;
      if (idx >= DEPTH) idx = idx - DEPTH;
      if (k < int'(cnt_q) && match[idx]) begin
        lk_hit  = 1'b1;
        lk_data = d_q[idx];
      end
    end
  end

  assign head_addr = a_q[head_q];
  assign head_data = d_q[head_q];
  assign count     = cnt_q;
  assign full      = (cnt_q == CW'(DEPTH));
  assign empty     = (cnt_q == '0);
endmodule

// File: rtl/stbuf_ctrl.sv
module stbuf_ctrl
  import stbuf_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_valid,
  input  logic [1:0]    cpu_op,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_stall,
  output logic          cpu_rvalid,
  output logic [DW-1:0] cpu_rdata,
  input  logic          q_full,
  input  logic          q_empty,
  input  logic          lk_hit,
  input  logic [DW-1:0] lk_data,
  output logic          push,
  output logic          c_req,
  output logic [1:0]    c_op,
  output logic [AW-1:0] c_addr,
  output logic [DW-1:0] c_wdata,
  input  logic          c_gnt,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata
);
  ctrl_st_e      st_q;
  logic [AW-1:0] p_addr_q;
  logic [DW-1:0] p_data_q;
  logic          idle, take;

  assign idle      = (st_q == S_IDLE);
  assign cpu_stall = !idle || (cpu_valid && cpu_op == OP_STORE && q_full);
  assign take      = cpu_valid && !cpu_stall;
  assign push      = take && cpu_op == OP_STORE;

  assign c_req   = (st_q == S_LD_REQ) || (st_q == S_X_REQ);
  assign c_op    = (st_q == S_X_REQ) ? MEM_SWAP : MEM_RD;
  assign c_addr  = p_addr_q;
  assign c_wdata = p_data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= S_IDLE;
      cpu_rvalid <= 1'b0;
      cpu_rdata  <= '0;
      p_addr_q   <= '0;
      p_data_q   <= '0;
    end else begin
      cpu_rvalid <= 1'b0;
      case (st_q)
        S_IDLE: begin
          if (take) begin
            if (cpu_op == OP_LOAD) begin
              if (lk_hit) begin
                cpu_rvalid <= 1'b1;
                cpu_rdata  <= lk_data;
              end else begin
                p_addr_q <= cpu_addr;
                st_q     <= S_LD_REQ;
              end
            end else if (cpu_op == OP_XCHG) begin
              p_addr_q <= cpu_addr;
              p_data_q <= cpu_wdata;
              st_q     <= S_X_DRAIN;
            end
          end
        end
        S_LD_REQ:  if (c_gnt) st_q <= S_LD_WAIT;
        S_X_DRAIN: if (q_empty) st_q <= S_X_REQ;
        S_X_REQ:   if (c_gnt) st_q <= S_X_WAIT;
        S_LD_WAIT, S_X_WAIT: begin
          if (mem_rvalid) begin
            cpu_rvalid <= 1'b1;
            cpu_rdata  <= mem_rdata;
            st_q       <= S_IDLE;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/stbuf_port_arb.sv
module stbuf_port_arb
  import stbuf_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          c_req,
  input  logic [1:0]    c_op,
  input  logic [AW-1:0] c_addr,
  input  logic [DW-1:0] c_wdata,
  output logic          c_gnt,
  input  logic          d_valid,
  input  logic [AW-1:0] d_addr,
  input  logic [DW-1:0] d_data,
  output logic          d_pop,
  output logic          mem_req,
  output logic [1:0]    mem_op,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_gnt
);
  always_comb begin
    if (c_req) begin
      mem_req   = 1'b1;
      mem_op    = c_op;
      mem_addr  = c_addr;
      mem_wdata = c_wdata;
    end else begin
      mem_req   = d_valid;
      mem_op    = MEM_WR;
      mem_addr  = d_addr;
      mem_wdata = d_data;
    end
  end

  assign c_gnt = c_req && mem_gnt;
  assign d_pop = !c_req && d_valid && mem_gnt;
endmodule

// File: rtl/stbuf_top.sv
module stbuf_top #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_valid,
  input  logic [1:0]    cpu_op,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_stall,
  output logic          cpu_rvalid,
  output logic [DW-1:0] cpu_rdata,
  output logic          mem_req,
  output logic [1:0]    mem_op,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_gnt,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata
);
  localparam int CW = $clog2(DEPTH + 1);

  logic          push, pop, q_full, q_empty, lk_hit, c_req, c_gnt;
  logic [DW-1:0] lk_data, head_data, c_wdata;
  logic [AW-1:0] head_addr, c_addr;
  logic [1:0]    c_op;
  logic [CW-1:0] fifo_cnt;

  stbuf_fifo #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fifo (
    .clk(clk), .rst(rst),
    .push(push), .push_addr(cpu_addr), .push_data(cpu_wdata),
    .pop(pop), .lk_addr(cpu_addr), .lk_hit(lk_hit), .lk_data(lk_data),
    .head_addr(head_addr), .head_data(head_data),
    .count(fifo_cnt), .full(q_full), .empty(q_empty)
  );

  stbuf_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk(clk), .rst(rst),
    .cpu_valid(cpu_valid), .cpu_op(cpu_op), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_stall(cpu_stall), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
    .q_full(q_full), .q_empty(q_empty), .lk_hit(lk_hit), .lk_data(lk_data),
    .push(push), .c_req(c_req), .c_op(c_op), .c_addr(c_addr), .c_wdata(c_wdata),
    .c_gnt(c_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  stbuf_port_arb #(.AW(AW), .DW(DW)) u_arb (
    .c_req(c_req), .c_op(c_op), .c_addr(c_addr), .c_wdata(c_wdata), .c_gnt(c_gnt),
    .d_valid(!q_empty), .d_addr(head_addr), .d_data(head_data), .d_pop(pop),
    .mem_req(mem_req), .mem_op(mem_op), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt)
  );
endmodule

// File: rtl/stbuf_chk.sv
module stbuf_chk #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int CW    = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          cpu_valid,
  input logic [1:0]    cpu_op,
  input logic          cpu_stall,
  input logic          cpu_rvalid,
  input logic          mem_req,
  input logic [1:0]    mem_op,
  input logic [AW-1:0] mem_addr,
  input logic          mem_gnt,
  input logic [CW-1:0] fifo_cnt
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!cpu_rvalid && !mem_req && fifo_cnt == '0));

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (fifo_cnt == CW'(DEPTH) && cpu_valid && cpu_op == 2'd1) |-> cpu_stall);

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_cnt <= CW'(DEPTH));

  // R2
  write_from_queue_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_op == 2'd1) |-> fifo_cnt != '0);

  // R8
  swap_after_drain_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_op == 2'd2) |-> fifo_cnt == '0);

  // R7
  read_held_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_op == 2'd0 && !mem_gnt) |=>
      (mem_req && mem_op == 2'd0 && $stable(mem_addr)));
endmodule

bind stbuf_top stbuf_chk #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_op(cpu_op),
  .cpu_stall(cpu_stall), .cpu_rvalid(cpu_rvalid), .mem_req(mem_req),
  .mem_op(mem_op), .mem_addr(mem_addr), .mem_gnt(mem_gnt), .fifo_cnt(fifo_cnt)
);

// File: tb/test_stbuf_top.sv
module test_stbuf_top;
  localparam int CLK_P = 10;
  localparam int DEPTH = 4;
  localparam int AW    = 16;
  localparam int DW    = 32;

  typedef struct packed {
    logic [1:0]    op;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    logic [DW-1:0] e;
  } vec_t;

  // op 0 load, 1 store, 2 exchange; e = expected result under sequential order
  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 16'd3, 32'h0,  32'h0000A003},
    '{2'd1, 16'd3, 32'h11, 32'h0},
    '{2'd1, 16'd5, 32'h22, 32'h0},
    '{2'd1, 16'd3, 32'h33, 32'h0},
    '{2'd0, 16'd3, 32'h0,  32'h33},
    '{2'd0, 16'd7, 32'h0,  32'h0000A007},
    '{2'd2, 16'd5, 32'h44, 32'h22},
    '{2'd0, 16'd5, 32'h0,  32'h44},
    '{2'd1, 16'd1, 32'h55, 32'h0},
    '{2'd0, 16'd1, 32'h0,  32'h55},
    '{2'd0, 16'd2, 32'h0,  32'h0000A002},
    '{2'd2, 16'd1, 32'h66, 32'h55},
    '{2'd0, 16'd1, 32'h0,  32'h66}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cpu_valid = 1'b0;
  logic [1:0]    cpu_op = '0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic          cpu_stall, cpu_rvalid;
  logic [DW-1:0] cpu_rdata;
  logic          mem_req, mem_gnt;
  logic [1:0]    mem_op;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_rvalid = 1'b0;
  logic [DW-1:0] mem_rdata = '0;

  int checks = 0;
  int failures = 0;

  logic gnt_en = 1'b1;
  logic gnt_alt = 1'b0;
  logic mem_init = 1'b0;
  logic cyc = 1'b0;

  logic [DW-1:0] mem [16];
  logic [AW-1:0] wlog_a [32];
  logic [DW-1:0] wlog_d [32];
  int wr_cnt = 0, rd_cnt = 0, rd_wr_seen = -1, sw_wr_seen = -1;
  logic          rsp_pend = 1'b0;
  logic          rsp_dly = 1'b0;
  logic [DW-1:0] rsp_val = '0;

  always #(CLK_P/2) clk = ~clk;

  assign mem_gnt = gnt_en && (!gnt_alt || cyc);

  stbuf_top #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) i_stbuf_top (
    .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_op(cpu_op),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_stall(cpu_stall),
    .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata), .mem_req(mem_req),
    .mem_op(mem_op), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  // memory model: response two cycles after the grant of a read or swap
  always @(posedge clk) begin
    cyc <= ~cyc;
    mem_rvalid <= 1'b0;
    if (mem_init) begin
      for (int i = 0; i < 16; i++) mem[i] <= 32'h0000A000 + i;
      wr_cnt <= 0; rd_cnt <= 0; rd_wr_seen <= -1; sw_wr_seen <= -1;
      rsp_pend <= 1'b0;
    end else begin
      if (rsp_pend) begin
        if (rsp_dly) rsp_dly <= 1'b0;
        else begin
          mem_rvalid <= 1'b1;
          mem_rdata  <= rsp_val;
          rsp_pend   <= 1'b0;
        end
      end
      if (mem_req && mem_gnt) begin
        case (mem_op)
          2'd1: begin
            mem[mem_addr[3:0]] <= mem_wdata;
            if (wr_cnt < 32) begin
              wlog_a[wr_cnt] <= mem_addr;
              wlog_d[wr_cnt] <= mem_wdata;
            end
            wr_cnt <= wr_cnt + 1;
          end
          2'd0: begin
            rsp_val <= mem[mem_addr[3:0]];
            rsp_pend <= 1'b1; rsp_dly <= 1'b1;
            rd_cnt <= rd_cnt + 1; rd_wr_seen <= wr_cnt;
          end
          default: begin
            rsp_val <= mem[mem_addr[3:0]];
            mem[mem_addr[3:0]] <= mem_wdata;
            rsp_pend <= 1'b1; rsp_dly <= 1'b1;
            sw_wr_seen <= wr_cnt;
          end
        endcase
      end
    end
  end

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; cpu_valid = 1'b0; mem_init = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0; mem_init = 1'b0;
  endtask

  task automatic do_req(input logic [1:0] op, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, output logic [DW-1:0] rd, output int lat);
    int w;
    @(negedge clk);
    cpu_valid = 1'b1; cpu_op = op; cpu_addr = a; cpu_wdata = d;
    #1;
    w = 0;
    while (cpu_stall && w < 500) begin
      @(negedge clk); #1; w++;
    end
    @(negedge clk);
    cpu_valid = 1'b0;
    lat = 1; rd = '0;
    if (op != 2'd1) begin
      while (!cpu_rvalid && lat < 500) begin
        @(negedge clk); lat++;
      end
      rd = cpu_rdata;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [DW-1:0] rd;
    int lat, rd0;

    // R1 reset state
    do_reset();
    @(negedge clk); #1;
    chk("R1 stall", cpu_stall, 1'b0);
    chk("R1 rvalid", cpu_rvalid, 1'b0);
    chk("R1 mem_req", mem_req, 1'b0);

    // table: full grant, then grant on alternate cycles
    for (int mode = 0; mode < 2; mode++) begin
      do_reset();
      gnt_en = 1'b1; gnt_alt = (mode == 1);
      for (int v = 0; v < NV; v++) begin
        do_req(VECS[v].op, VECS[v].a, VECS[v].d, rd, lat);
        if (VECS[v].op != 2'd1) chk("R5/R6/R7/R8 table", rd, VECS[v].e);
      end
    end

    // directed: blocked memory fills the queue
    do_reset();
    gnt_alt = 1'b0; gnt_en = 1'b0;
    do_req(2'd1, 16'd9, 32'd1, rd, lat);
    do_req(2'd1, 16'd9, 32'd2, rd, lat);
    do_req(2'd1, 16'd4, 32'd7, rd, lat);
    do_req(2'd1, 16'd9, 32'd3, rd, lat);
    @(negedge clk);
    cpu_valid = 1'b1; cpu_op = 2'd1; cpu_addr = 16'd6; cpu_wdata = 32'd8;
    #1; chk("R3 stall when full", cpu_stall, 1'b1);
    @(negedge clk); #1; chk("R3 stall held", cpu_stall, 1'b1);
    cpu_valid = 1'b0;

    rd0 = rd_cnt;
    do_req(2'd0, 16'd9, 32'd0, rd, lat);
    chk("R6 youngest", rd, 32'd3);
    chk("R5 latency", 32'(lat), 32'd1);
    do_req(2'd0, 16'd4, 32'd0, rd, lat);
    chk("R5 hit data", rd, 32'd7);
    chk("R5 no mem read", 32'(rd_cnt), 32'(rd0));

    // miss overtakes queued writes
    @(negedge clk);
    cpu_valid = 1'b1; cpu_op = 2'd0; cpu_addr = 16'd2;
    #1; chk("R4 load taken", cpu_stall, 1'b0);
    @(negedge clk); cpu_valid = 1'b0; #1;
    chk("R4 read issued", {mem_req, mem_op, mem_addr}, {1'b1, 2'd0, 16'd2});
    chk("R7 stall while waiting", cpu_stall, 1'b1);
    gnt_en = 1'b1;
    lat = 0;
    while (!cpu_rvalid && lat < 500) begin @(negedge clk); lat++; end
    chk("R7 miss data", cpu_rdata, 32'h0000A002);
    chk("R4 read before writes", 32'(rd_wr_seen), 32'd0);

    // exchange drains first
    do_req(2'd2, 16'd9, 32'd50, rd, lat);
    chk("R8 old value", rd, 32'd3);
    chk("R8 swap after four writes", 32'(sw_wr_seen), 32'd4);
    chk("R2 order", {wlog_a[0], wlog_a[1], wlog_a[2], wlog_a[3]}, {16'd9, 16'd9, 16'd4, 16'd9});
    chk("R2 data", {wlog_d[0], wlog_d[1], wlog_d[2], wlog_d[3]}, {32'd1, 32'd2, 32'd7, 32'd3});
    do_req(2'd0, 16'd9, 32'd0, rd, lat);
    chk("R8 new value", rd, 32'd50);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule